// File: doc/BRIEF.md
# Receive FIFO with automatic RTS

This block sits behind a UART deserializer. Each received character arrives as a one-cycle strobe with its data byte. The block stores it in a first-in, first-out buffer that the host drains through a read strobe. The oldest stored byte is always shown on `rd_data`. The block also reports the fill level, the empty and full flags, and a sticky overrun flag.

The block drives the active-low request-to-send output `rts_n`, which tells the remote transmitter to pause or resume. Automatic flow control is active only when three control bits are all set: the FIFO enable, the manual RTS bit and the auto-flow enable. In that mode a two-state machine controls `rts_n`:

- `RTS_OPEN` keeps `rts_n` low.
- The *raise* transition moves to `RTS_THROTTLE` once the level reaches the selected threshold, and `RTS_THROTTLE` holds `rts_n` high.
- The *release* transition returns to `RTS_OPEN` only after the buffer has been fully drained. This gives hysteresis.
- When automatic mode is not active, the *auto-off* transition forces `RTS_OPEN`, and `rts_n` simply follows the inverse of the manual RTS bit.

With the FIFO disabled, the buffer holds a single character.

Top module: `rx_flow_buffer`

## Requirements
- R1: After reset the level is 0, `empty` is 1, `full` is 0, `overrun` is 0 and `rts_n` is 1.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest stored byte. A `host_rd` pulse removes one entry when the buffer is not empty, and it has no effect when the buffer is empty.
- R3: `level` counts stored entries. The capacity is 16 when `fifo_en` is 1 and 1 when `fifo_en` is 0. `full` is 1 when the level is at or above the capacity, and `empty` is 1 when the level is 0.
- R4: A character is accepted if the level, minus one when a read happens in the same cycle, is below the capacity. Otherwise the character is dropped: the level and the stored data are unchanged and `overrun` is set.
- R5: `overrun` stays set until an `ovr_clr` pulse. If a drop and `ovr_clr` fall in the same cycle, `overrun` ends up set.
- R6: When `fifo_en`, `rts_bit` and `auto_flow_en` are not all 1, `rts_n` equals the inverse of `rts_bit` one clock later.
- R7: In automatic mode `rts_n` goes high on the clock after the level reaches the threshold. The threshold is chosen by `thr_sel`: 0 gives 1 entry, 1 gives 4 entries, 2 gives 8 entries and 3 gives 14 entries.
- R8: Once high in automatic mode, `rts_n` stays high while the level is non-zero, even below the threshold. It returns low on the clock after the level is 0.
- R9: With `thr_sel` set to 3, the buffer absorbs the characters that arrive after `rts_n` rises, up to the full 16 entries, without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe for a received character |
| char_data | input | 8 | Received character |
| host_rd | input | 1 | Host read strobe; removes the oldest entry |
| ovr_clr | input | 1 | Clears the overrun flag |
| fifo_en | input | 1 | FIFO enable (capacity 16, else 1) |
| rts_bit | input | 1 | Manual RTS control bit |
| auto_flow_en | input | 1 | Automatic flow control enable |
| thr_sel | input | 2 | Threshold select: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14 |
| rd_data | output | 8 | Oldest stored byte |
| level | output | 5 | Number of stored entries |
| empty | output | 1 | Buffer is empty |
| full | output | 1 | Buffer is at capacity |
| overrun | output | 1 | Sticky flag for a dropped character |
| rts_n | output | 1 | Active-low request to send |

## Verification
The two functions that share a cycle are the character push and the host pop. Overrun detection also coincides with its own clear strobe. The bench fills the buffer to capacity at every threshold setting and then drives a push and a read in the same cycle. That push must land while the level stays unchanged. It also drives a push into a full buffer together with `ovr_clr`, where the flag must end up set. Every cycle the bench compares level, flags, head data and `rts_n` against a queue model that it updates from the requirements.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    typedef enum logic {
        RTS_OPEN     = 1'b0,
        RTS_THROTTLE = 1'b1
    } rts_state_t;

    typedef enum logic [1:0] {
        THR_ONE      = 2'd0,
        THR_QUARTER  = 2'd1,
        THR_HALF     = 2'd2,
        THR_NEARFULL = 2'd3
    } thr_sel_t;

    // Entry count at which the sender is throttled
    function automatic int unsigned thr_level(input logic [1:0] sel, input int unsigned depth);
        int unsigned r;
        case (thr_sel_t'(sel))
            THR_ONE:      r = 1;
            THR_QUARTER:  r = depth / 4;
            THR_HALF:     r = depth / 2;
            default:      r = depth - 2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    input  logic             ovr_clr,
    output logic [WIDTH-1:0] head_data,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full,
    output logic             overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [LW-1:0]    level_q;
    logic             ovr_q;
    logic [LW-1:0]    cap;
    logic             pop_ok, push_ok, drop;

    always_comb begin
        cap     = fifo_en ? LW'(DEPTH) : LW'(1);
        pop_ok  = pop_req && (level_q != '0);
        push_ok = push_req && ((level_q - LW'(pop_ok)) < cap);
        drop    = push_req && !push_ok;
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
            ovr_q   <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            level_q <= level_q + LW'(push_ok) - LW'(pop_ok);
            if (drop) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign head_data = mem[rd_ptr];
    assign level     = level_q;
    assign empty     = (level_q == '0);
    assign full      = (level_q >= cap);
    assign overrun   = ovr_q;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R4
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req) |=> (level == $past(level) && overrun));

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R2
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !push_req) |=> empty);

    // R2
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && pop_req && !push_req) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/rxq_rts_fsm.sv
`timescale 1ns/1ps
module rxq_rts_fsm #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          auto_on,
    input  logic          manual_bit,
    input  logic [1:0]    thr_sel,
    input  logic [LW-1:0] level,
    output logic          rts_n
);
    import rxq_pkg::*;

    rts_state_t    state_q, state_d;
    logic          rts_n_q, rts_n_d;
    logic [LW-1:0] thr;

    assign thr = LW'(thr_level(thr_sel, DEPTH));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!auto_on) begin
            state_d = RTS_OPEN;
        end else begin
            unique case (state_q)
                RTS_OPEN:     if (level >= thr)  state_d = RTS_THROTTLE;
                RTS_THROTTLE: if (level == '0)   state_d = RTS_OPEN;
            endcase
        end
    end

    // Output logic
    always_comb begin
        if (auto_on) begin
            rts_n_d = (state_d == RTS_THROTTLE);
        end else begin
            rts_n_d = !manual_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RTS_OPEN;
            rts_n_q <= 1'b1;
        end else begin
            state_q <= state_d;
            rts_n_q <= rts_n_d;
        end
    end

    assign rts_n = rts_n_q;

    // R7
    raise_at_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && level >= thr) |=> rts_n);

    // R8
    hold_until_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RTS_THROTTLE && auto_on && level != '0) |=> rts_n);

    // R6
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_on |=> (rts_n == !$past(manual_bit)));

endmodule

// File: rtl/rx_flow_buffer.sv
`timescale 1ns/1ps
module rx_flow_buffer #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             char_valid,
    input  logic [WIDTH-1:0] char_data,
    input  logic             host_rd,
    input  logic             ovr_clr,
    input  logic             fifo_en,
    input  logic             rts_bit,
    input  logic             auto_flow_en,
    input  logic [1:0]       thr_sel,
    output logic [WIDTH-1:0] rd_data,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full,
    output logic             overrun,
    output logic             rts_n
);
    logic auto_on;

    assign auto_on = fifo_en && rts_bit && auto_flow_en;

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LW(LW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .push_req  (char_valid),
        .push_data (char_data),
        .pop_req   (host_rd),
        .ovr_clr   (ovr_clr),
        .head_data (rd_data),
        .level     (level),
        .empty     (empty),
        .full      (full),
        .overrun   (overrun)
    );

    rxq_rts_fsm #(.DEPTH(DEPTH), .LW(LW)) i_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_on    (auto_on),
        .manual_bit (rts_bit),
        .thr_sel    (thr_sel),
        .level      (level),
        .rts_n      (rts_n)
    );

endmodule

// File: tb/test_rx_flow_buffer.sv
`timescale 1ns/1ps
module test_rx_flow_buffer;
    localparam int DEPTH = 16;
    localparam int LW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          char_valid = 1'b0;
    logic [7:0]    char_data = '0;
    logic          host_rd = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          fifo_en = 1'b1;
    logic          rts_bit = 1'b0;
    logic          auto_flow_en = 1'b0;
    logic [1:0]    thr_sel = 2'd0;
    logic [7:0]    rd_data;
    logic [LW-1:0] level;
    logic          empty, full, overrun, rts_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int mq[$];
    bit movr = 0;
    bit mst  = 0;
    bit mrts = 1;

    always #2.5 clk = ~clk;

    rx_flow_buffer i_rx_flow_buffer (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .host_rd(host_rd), .ovr_clr(ovr_clr), .fifo_en(fifo_en), .rts_bit(rts_bit),
        .auto_flow_en(auto_flow_en), .thr_sel(thr_sel), .rd_data(rd_data),
        .level(level), .empty(empty), .full(full), .overrun(overrun), .rts_n(rts_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int thr_of(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? DEPTH / 4 : (sel == 2) ? DEPTH / 2 : DEPTH - 2;
    endfunction

    task automatic check_all();
        int  cap;
        bit  auto_on;
        cap = fifo_en ? DEPTH : 1;
        auto_on = fifo_en && rts_bit && auto_flow_en;
        chk(int'(level) == mq.size(), "R3 level", int'(level), mq.size());
        chk(full == (mq.size() >= cap), "R3 full", int'(full), int'(mq.size() >= cap));
        chk(empty == (mq.size() == 0), "R2 empty", int'(empty), int'(mq.size() == 0));
        if (mq.size() > 0) begin
            chk(int'(rd_data) == mq[0], "R2 head data", int'(rd_data), mq[0]);
        end
        chk(overrun == movr, "R4/R5 overrun", int'(overrun), int'(movr));
        if (!auto_on) begin
            chk(rts_n == mrts, "R6 manual rts_n", int'(rts_n), int'(mrts));
        end else if (mst && mq.size() > 0) begin
            chk(rts_n == mrts, "R8 hold rts_n", int'(rts_n), int'(mrts));
        end else begin
            chk(rts_n == mrts, "R7 auto rts_n", int'(rts_n), int'(mrts));
        end
    endtask

    task automatic cyc(input bit v, input int d, input bit rd, input bit clr);
        bit pop;
        bit push;
        int cap;
        int lev_old;
        bit auto_on;
        cap = fifo_en ? DEPTH : 1;
        lev_old = mq.size();
        pop = rd && (lev_old > 0);
        push = v && ((lev_old - int'(pop)) < cap);
        auto_on = fifo_en && rts_bit && auto_flow_en;
        if (!auto_on) begin
            mst = 0;
            mrts = !rts_bit;
        end else begin
            if (!mst && lev_old >= thr_of(int'(thr_sel))) mst = 1;
            else if (mst && lev_old == 0) mst = 0;
            mrts = mst;
        end
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(d & 255);
        if (v && !push) movr = 1;
        else if (clr) movr = 0;
        char_valid = v;
        char_data = 8'(d);
        host_rd = rd;
        ovr_clr = clr;
        @(posedge clk);
        #1;
        char_valid = 0;
        host_rd = 0;
        ovr_clr = 0;
        check_all();
    endtask

    task automatic drain();
        while (mq.size() > 0) cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #12;
        // R1 reset state
        chk(level == 0 && empty && !full && !overrun && rts_n, "R1 reset",
            {level, empty, full, overrun, rts_n}, {5'd0, 4'b1001});
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        rts_bit = 1;
        auto_flow_en = 1;
        fifo_en = 1;

        // Threshold sweep: fill past capacity, clear, push+pop at full, drain
        for (int t = 0; t < 4; t++) begin
            thr_sel = 2'(t);
            for (int i = 0; i < DEPTH + 2; i++) begin
                cyc(1, t * 40 + i + 1, 0, 0);
                if (t == 3 && i == DEPTH - 1) begin
                    chk(!overrun && rts_n && level == DEPTH, "R9 margin",
                        int'(overrun), 0);
                end
            end
            cyc(0, 0, 0, 1);
            cyc(1, 8'hA5 ^ t, 1, 0);
            cyc(1, 8'h5A, 0, 1);
            cyc(0, 0, 0, 1);
            drain();
        end

        // Empty reads ignored
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 0);

        // Interleaved traffic at half threshold
        thr_sel = 2'd2;
        for (int i = 0; i < 40; i++) begin
            cyc((i % 3) != 2, i * 7, (i % 4) == 3, 0);
        end
        drain();

        // Mode sweep with entries stored
        thr_sel = 2'd1;
        for (int i = 0; i < 5; i++) cyc(1, 100 + i, 0, 0);
        for (int m = 0; m < 8; m++) begin
            fifo_en = m[0];
            rts_bit = m[1];
            auto_flow_en = m[2];
            cyc(0, 0, 0, 0);
            cyc(0, 0, 0, 0);
        end
        fifo_en = 1;
        rts_bit = 1;
        auto_flow_en = 1;
        drain();

        // FIFO disabled: capacity one
        fifo_en = 0;
        cyc(1, 8'h11, 0, 0);
        cyc(1, 8'h22, 0, 0);
        cyc(1, 8'h33, 1, 0);
        cyc(0, 0, 1, 1);
        cyc(0, 0, 0, 0);
        rts_bit = 0;
        cyc(0, 0, 0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule